// File: doc/BRIEF.md
# Pseudo-Channel Request Admission Router

This block sits in front of a memory controller that splits its storage into two pseudo-channels. A requester presents one read or write at a time with a byte address and a byte length. A single address bit picks the pseudo-channel. The router works out how many fixed-size memory bursts the request touches. It then checks that the chosen channel's queue can take all of those bursts before it commits to the request.

An admitted request is split into burst descriptors. The descriptors go into the chosen channel's queue one per clock. The request handshake completes only with the last descriptor. A request that does not fit is turned away at once and leaves a pending-retry mark. There are four such marks: one for each pair of channel and direction. A mark is released, with a one-cycle retry pulse, once its queue falls back under the limit. Each channel also has a write-drain flag with hysteresis, driven from its write occupancy.

Occupancy comes back from external queues. The read check adds the channel's outstanding response count to its read queue count. Each channel's limit is half of the combined buffer of both channels.

Top module: `pc_admit_router`

## Requirements
- R1: Address bit CH_BIT (default 6) selects the channel: value 0 pushes on push_o[0], value 1 on push_o[1]. All bursts of a request go to that one channel.
- R2: A legal request needs ceil(((addr mod BURST_BYTES) + size) / BURST_BYTES) bursts. Default BURST_BYTES is 32. Descriptor k carries the address (addr rounded down to BURST_BYTES) + k*BURST_BYTES, and push_write_o equals the request direction.
- R3: Descriptors are pushed one per clock, at most one channel per clock. req_ready_o rises only in the cycle of the last push, and the request is held stalled until then.
- R4: A write (req_cmd_i = 2'b10) is turned away when the channel's write occupancy plus the needed bursts exceeds WR_LIM = (WR_BUF0+WR_BUF1)/2. It is then completed with req_ready_o and req_nack_o high and no push. The default WR_LIM is 8.
- R5: A read (req_cmd_i = 2'b01) is turned away when read occupancy plus response occupancy plus the needed bursts exceeds RD_LIM = (RD_BUF0+RD_BUF1)/2. The default RD_LIM is 8. A sum equal to the limit is admitted.
- R6: A refusal sets only the pending mark of its own channel and direction: rd_retry_pend_o[ch] or wr_retry_pend_o[ch].
- R7: A pending mark clears, with the matching retry pulse high for exactly that one cycle, in the clock after its total occupancy is below the limit. A refusal in the same clock keeps the mark set and gives no pulse.
- R8: Commands 2'b00 and 2'b11, and reads of size zero, complete with req_ready_o and req_err_o high. They push nothing and leave every pending mark as it was.
- R9: wr_drain_o[ch] sets in the clock after write occupancy >= (WR_LIM*HI_PCT)/100 and clears after it is <= (WR_LIM*LO_PCT)/100; between the two it holds. With the defaults the marks are 6 and 4.
- R10: After reset, no push, no ready, and no pending, pulse or drain output is high.
- R11: A write that needs zero bursts (size 0 at an aligned address) completes with req_ready_o high, no push and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held until req_ready_o |
| req_cmd_i | input | 2 | 01 read, 10 write, others illegal |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | SIZE_W | Byte length |
| req_ready_o | output | 1 | Request completed this cycle |
| req_nack_o | output | 1 | Completed request was refused for lack of room |
| req_err_o | output | 1 | Completed request was illegal |
| rd_occ_i | input | 2 x OCC_W | Read queue occupancy per channel |
| rsp_occ_i | input | 2 x OCC_W | Outstanding response count per channel |
| wr_occ_i | input | 2 x OCC_W | Write queue occupancy per channel |
| push_o | output | 2 | Descriptor push strobe per channel |
| push_addr_o | output | ADDR_W | Burst-aligned descriptor address |
| push_write_o | output | 1 | Descriptor direction, 1 for write |
| rd_retry_pend_o | output | 2 | Read retry pending per channel |
| wr_retry_pend_o | output | 2 | Write retry pending per channel |
| rd_retry_o | output | 2 | One-cycle read retry pulse per channel |
| wr_retry_o | output | 2 | One-cycle write retry pulse per channel |
| wr_drain_o | output | 2 | Write-drain flag per channel |

## Verification
A refusal can set a pending mark in the same clock in which that mark's release condition also holds. For example, a two-burst write can be refused at write occupancy 7 while 7 is already under the limit of 8. The bench provokes this and requires the mark to read set with no pulse after that edge, then clear with a single pulse one clock later. A second case holds occupancy at exactly the limit, so that the mark stays set until the bench lowers it. The bench also places admitted reads right on the limit sum, alongside a refused read one burst over it.

// File: rtl/pcar_pkg.sv
package pcar_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_BAD  = 2'b11
  } cmd_e;

  function automatic int pct_of(input int base, input int pct);
    return (base * pct) / 100;
  endfunction
endpackage

// File: rtl/pcar_burst_calc.sv
module pcar_burst_calc #(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 32,
  parameter int OFF_W       = 5,
  parameter int TOT_W       = 9,
  parameter int NEED_W      = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [NEED_W-1:0] need_o
);
  logic [TOT_W:0] tot;

  // offset + size, rounded up to whole bursts
  always_comb begin
    tot = (TOT_W+1)'(addr_i[OFF_W-1:0]) + (TOT_W+1)'(size_i)
        + (TOT_W+1)'(BURST_BYTES - 1);
    need_o = tot[TOT_W:OFF_W];
  end

  logic unused_hi;
  assign unused_hi = ^addr_i[ADDR_W-1:OFF_W];
endmodule

// File: rtl/pcar_ch_admit.sv
module pcar_ch_admit #(
  parameter int OCC_W  = 6,
  parameter int NEED_W = 5,
  parameter int RD_LIM = 8,
  parameter int WR_LIM = 8,
  parameter int HI_MK  = 6,
  parameter int LO_MK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OCC_W-1:0]  rd_occ_i,
  input  logic [OCC_W-1:0]  rsp_occ_i,
  input  logic [OCC_W-1:0]  wr_occ_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              rd_fit_o,
  output logic              wr_fit_o,
  output logic              rd_below_o,
  output logic              wr_below_o,
  output logic              drain_o
);
  localparam int SUM_W = ((OCC_W > NEED_W) ? OCC_W : NEED_W) + 2;

  logic [SUM_W-1:0] rd_base, rd_tot, wr_tot;

  always_comb begin
    rd_base    = SUM_W'(rd_occ_i) + SUM_W'(rsp_occ_i);
    rd_tot     = rd_base + SUM_W'(need_i);
    wr_tot     = SUM_W'(wr_occ_i) + SUM_W'(need_i);
    rd_fit_o   = rd_tot <= SUM_W'(RD_LIM);
    wr_fit_o   = wr_tot <= SUM_W'(WR_LIM);
    rd_below_o = rd_base < SUM_W'(RD_LIM);
    wr_below_o = SUM_W'(wr_occ_i) < SUM_W'(WR_LIM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            drain_o <= 1'b0;
    else if (SUM_W'(wr_occ_i) >= SUM_W'(HI_MK)) drain_o <= 1'b1;
    else if (SUM_W'(wr_occ_i) <= SUM_W'(LO_MK)) drain_o <= 1'b0;
  end

  // R9
  drain_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_o) |-> SUM_W'($past(wr_occ_i)) >= SUM_W'(HI_MK));
  // R9
  drain_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drain_o) |-> SUM_W'($past(wr_occ_i)) <= SUM_W'(LO_MK));
endmodule

// File: rtl/pcar_retry_flag.sv
module pcar_retry_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic below_i,
  output logic pend_o,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else if (set_i) begin
      pend_o  <= 1'b1;   // refusal wins over release
      pulse_o <= 1'b0;
    end else if (pend_o && below_i) begin
      pend_o  <= 1'b0;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R7
  pulse_after_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(pend_o) && !pend_o));
  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/pc_admit_router.sv
module pc_admit_router
  import pcar_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 32,
  parameter int CH_BIT      = 6,
  parameter int OCC_W       = 6,
  parameter int RD_BUF0     = 8,
  parameter int RD_BUF1     = 8,
  parameter int WR_BUF0     = 8,
  parameter int WR_BUF1     = 8,
  parameter int HI_PCT      = 85,
  parameter int LO_PCT      = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [1:0]            req_cmd_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [SIZE_W-1:0]     req_size_i,
  output logic                  req_ready_o,
  output logic                  req_nack_o,
  output logic                  req_err_o,
  input  logic [1:0][OCC_W-1:0] rd_occ_i,
  input  logic [1:0][OCC_W-1:0] rsp_occ_i,
  input  logic [1:0][OCC_W-1:0] wr_occ_i,
  output logic [1:0]            push_o,
  output logic [ADDR_W-1:0]     push_addr_o,
  output logic                  push_write_o,
  output logic [1:0]            rd_retry_pend_o,
  output logic [1:0]            wr_retry_pend_o,
  output logic [1:0]            rd_retry_o,
  output logic [1:0]            wr_retry_o,
  output logic [1:0]            wr_drain_o
);
  localparam int OFF_W  = $clog2(BURST_BYTES);
  localparam int TOT_W  = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 1;
  localparam int NEED_W = TOT_W + 1 - OFF_W;
  localparam int RD_LIM = (RD_BUF0 + RD_BUF1) / 2;
  localparam int WR_LIM = (WR_BUF0 + WR_BUF1) / 2;
  localparam int HI_MK  = pct_of(WR_LIM, HI_PCT);
  localparam int LO_MK  = pct_of(WR_LIM, LO_PCT);

  cmd_e              cmd;
  logic              is_rd, is_wr, illegal, fits, ch_sel;
  logic [NEED_W-1:0] need, cur_idx, idx_q;
  logic              busy_q;
  logic [1:0]        rd_fit, wr_fit, rd_below, wr_below, rd_set, wr_set;

  assign cmd     = cmd_e'(req_cmd_i);
  assign is_rd   = (cmd == CMD_RD);
  assign is_wr   = (cmd == CMD_WR);
  assign illegal = !(is_rd || is_wr) || (is_rd && req_size_i == '0);
  assign ch_sel  = req_addr_i[CH_BIT];

  pcar_burst_calc #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BURST_BYTES(BURST_BYTES),
    .OFF_W(OFF_W), .TOT_W(TOT_W), .NEED_W(NEED_W)
  ) u_calc (
    .addr_i(req_addr_i), .size_i(req_size_i), .need_o(need)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    pcar_ch_admit #(
      .OCC_W(OCC_W), .NEED_W(NEED_W), .RD_LIM(RD_LIM), .WR_LIM(WR_LIM),
      .HI_MK(HI_MK), .LO_MK(LO_MK)
    ) u_admit (
      .clk_i, .rst_ni,
      .rd_occ_i(rd_occ_i[c]), .rsp_occ_i(rsp_occ_i[c]), .wr_occ_i(wr_occ_i[c]),
      .need_i(need),
      .rd_fit_o(rd_fit[c]), .wr_fit_o(wr_fit[c]),
      .rd_below_o(rd_below[c]), .wr_below_o(wr_below[c]),
      .drain_o(wr_drain_o[c])
    );

    assign rd_set[c] = req_nack_o && is_rd && (ch_sel == 1'(c));
    assign wr_set[c] = req_nack_o && is_wr && (ch_sel == 1'(c));

    pcar_retry_flag u_rd_retry (
      .clk_i, .rst_ni, .set_i(rd_set[c]), .below_i(rd_below[c]),
      .pend_o(rd_retry_pend_o[c]), .pulse_o(rd_retry_o[c])
    );
    pcar_retry_flag u_wr_retry (
      .clk_i, .rst_ni, .set_i(wr_set[c]), .below_i(wr_below[c]),
      .pend_o(wr_retry_pend_o[c]), .pulse_o(wr_retry_o[c])
    );
  end

  assign fits    = is_wr ? wr_fit[ch_sel] : rd_fit[ch_sel];
  assign cur_idx = busy_q ? idx_q : '0;

  always_comb begin
    req_ready_o = 1'b0;
    req_nack_o  = 1'b0;
    req_err_o   = 1'b0;
    push_o      = 2'b00;
    if (req_valid_i) begin
      if (busy_q) begin
        push_o[ch_sel] = 1'b1;
        req_ready_o    = (idx_q == need - 1'b1);
      end else if (illegal) begin
        req_ready_o = 1'b1;
        req_err_o   = 1'b1;
      end else if (!fits) begin
        req_ready_o = 1'b1;
        req_nack_o  = 1'b1;
      end else if (need == '0) begin
        req_ready_o = 1'b1;
      end else begin
        push_o[ch_sel] = 1'b1;
        req_ready_o    = (need == NEED_W'(1));
      end
    end
  end

  assign push_addr_o  = {req_addr_i[ADDR_W-1:OFF_W], OFF_W'(0)}
                      + (ADDR_W'(cur_idx) << OFF_W);
  assign push_write_o = is_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (req_ready_o) busy_q <= 1'b0;
      else             idx_q  <= idx_q + 1'b1;
    end else if (push_o != 2'b00 && !req_ready_o) begin
      busy_q <= 1'b1;
      idx_q  <= NEED_W'(1);
    end
  end

  // R3
  one_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_o));
  // R3
  hold_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> req_valid_i);
  // R3
  last_push_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(req_ready_o && push_o != 2'b00));
  // R6
  nack_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_nack_o |=> (rd_retry_pend_o != 2'b00 || wr_retry_pend_o != 2'b00));
endmodule

// File: tb/sim_pc_admit_router.sv
`timescale 1ns/1ps
module sim_pc_admit_router;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [1:0]       cmd = 2'b00;
  logic [31:0]      addr = '0;
  logic [7:0]       size = '0;
  logic             ready, nack, err, push_write;
  logic [1:0][5:0]  rd_occ, rsp_occ, wr_occ;
  logic [1:0]       push, rd_pend, wr_pend, rd_pul, wr_pul, drain;
  logic [31:0]      push_addr;
  int               n_chk = 0, n_bad = 0;
  bit               finished = 0;

  always #4 clk = ~clk;

  pc_admit_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_cmd_i(cmd), .req_addr_i(addr), .req_size_i(size),
    .req_ready_o(ready), .req_nack_o(nack), .req_err_o(err),
    .rd_occ_i(rd_occ), .rsp_occ_i(rsp_occ), .wr_occ_i(wr_occ),
    .push_o(push), .push_addr_o(push_addr), .push_write_o(push_write),
    .rd_retry_pend_o(rd_pend), .wr_retry_pend_o(wr_pend),
    .rd_retry_o(rd_pul), .wr_retry_o(wr_pul), .wr_drain_o(drain)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic flags(input string rq, input [1:0] rp, input [1:0] wp,
                       input [1:0] rpl, input [1:0] wpl);
    chk(rd_pend == rp, rq, "rd_pend", rd_pend, rp);
    chk(wr_pend == wp, rq, "wr_pend", wr_pend, wp);
    chk(rd_pul == rpl, rq, "rd_pulse", rd_pul, rpl);
    chk(wr_pul == wpl, rq, "wr_pulse", wr_pul, wpl);
  endtask

  // kind: 0 admit, 1 refuse, 2 illegal
  task automatic do_req(input [1:0] c, input [31:0] a, input [7:0] s,
                        input int exp_n, input int exp_ch, input int kind,
                        input string rq);
    int pushes = 0;
    bit done = 0;
    @(negedge clk);
    valid = 1'b1; cmd = c; addr = a; size = s;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      #1;
      if (push != 2'b00) begin
        chk(push == 2'(1 << exp_ch), rq, "push channel", push, 1 << exp_ch);
        chk(push_addr == {a[31:5], 5'b0} + 32'(pushes * 32), rq, "push addr",
            push_addr, {a[31:5], 5'b0} + 32'(pushes * 32));
        chk(push_write == (c == 2'b10), rq, "push dir", push_write, c == 2'b10);
        pushes++;
      end
      if (ready) begin
        done = 1;
        chk(nack == (kind == 1), rq, "nack", nack, kind == 1);
        chk(err == (kind == 2), rq, "err", err, kind == 2);
        chk(pushes == exp_n, "R3", {rq, " ready on last push"}, pushes, exp_n);
      end
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    chk(done, rq, "completed", done, 1);
    @(negedge clk);
    valid = 1'b0; cmd = 2'b00;
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk(ready == 0 && push == 0, "R10", "ready/push", {ready, push}, 0);
    flags("R10", 0, 0, 0, 0);
    chk(drain == 0, "R10", "drain", drain, 0);
  endtask

  task automatic t_route;
    do_req(2'b01, 32'h0000_0000, 8'd64, 2, 0, 0, "R1 R2 read ch0");
    do_req(2'b10, 32'h0000_005C, 8'd8, 2, 1, 0, "R1 R2 write ch1 unaligned");
    do_req(2'b01, 32'h0000_0003, 8'd32, 2, 0, 0, "R2 read offset 3");
    do_req(2'b01, 32'h0000_0100, 8'd200, 7, 0, 0, "R2 R3 seven bursts");
    do_req(2'b10, 32'h0000_01C0, 8'd1, 1, 1, 0, "R1 single burst");
  endtask

  task automatic t_wr_refuse;
    wr_occ[0] = 6'd7;
    do_req(2'b10, 32'h0, 8'd64, 0, 0, 1, "R4 write over limit");
    flags("R6 R7 set wins", 2'b00, 2'b01, 2'b00, 2'b00);
    @(negedge clk); #1;
    flags("R7 release", 2'b00, 2'b00, 2'b00, 2'b01);
    @(negedge clk); #1;
    flags("R7 pulse once", 2'b00, 2'b00, 2'b00, 2'b00);
    wr_occ[0] = 6'd8;
    do_req(2'b10, 32'h0, 8'd32, 0, 0, 1, "R4 at limit plus one");
    @(negedge clk); #1;
    flags("R7 hold at limit", 2'b00, 2'b01, 2'b00, 2'b00);
    wr_occ[0] = 6'd7;
    @(negedge clk); #1;
    flags("R7 release on drop", 2'b00, 2'b00, 2'b00, 2'b01);
    wr_occ[0] = 6'd6;
    do_req(2'b10, 32'h0, 8'd64, 2, 0, 0, "R4 exact fit");
    wr_occ[0] = 6'd0;
  endtask

  task automatic t_rd_refuse;
    rd_occ[1] = 6'd5; rsp_occ[1] = 6'd2;
    do_req(2'b01, 32'h40, 8'd64, 0, 1, 1, "R5 read over limit");
    flags("R6 read ch1 only", 2'b10, 2'b00, 2'b00, 2'b00);
    do_req(2'b01, 32'h40, 8'd32, 1, 1, 0, "R5 read sum equals limit");
    rd_occ[1] = 6'd0; rsp_occ[1] = 6'd0;
    @(negedge clk); @(negedge clk); #1;
    flags("R7 settled", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_illegal;
    wr_occ[1] = 6'd8;
    do_req(2'b11, 32'h40, 8'd64, 0, 1, 2, "R8 cmd 11");
    do_req(2'b00, 32'h0, 8'd8, 0, 0, 2, "R8 cmd 00");
    do_req(2'b01, 32'h0, 8'd0, 0, 0, 2, "R8 zero read");
    @(negedge clk); #1;
    flags("R8 no marks", 2'b00, 2'b00, 2'b00, 2'b00);
    wr_occ[1] = 6'd0;
    do_req(2'b10, 32'h80, 8'd0, 0, 0, 0, "R11 zero write");
  endtask

  task automatic t_drain;
    @(negedge clk); wr_occ[0] = 6'd5;
    @(negedge clk); #1;
    chk(drain[0] == 0, "R9", "below high mark", drain, 0);
    wr_occ[0] = 6'd6;
    @(negedge clk); #1;
    chk(drain == 2'b01, "R9", "at high mark", drain, 1);
    wr_occ[0] = 6'd5;
    @(negedge clk); #1;
    chk(drain == 2'b01, "R9", "hold between marks", drain, 1);
    wr_occ[0] = 6'd4;
    @(negedge clk); #1;
    chk(drain == 2'b00, "R9", "at low mark", drain, 0);
  endtask

  initial begin
    rd_occ = '0; rsp_occ = '0; wr_occ = '0;
    #20 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_route();
    t_wr_refuse();
    t_rd_refuse();
    t_illegal();
    t_drain();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule